// File: doc/BRIEF.md
# 64-bit PCI Master Read Sequencer

This block is the bus-master engine for 64-bit memory reads on a conventional parallel PCI bus. It acts for a local requester. The local side raises a request, and the sequencer asks the arbiter for the bus. Once granted, it waits until the bus is idle and then acknowledges the local address. It drives the address phase with both frame and the 64-bit request asserted. It then releases the address/data lanes for one turnaround cycle and runs data phases until the local side signals the last word.

Every word that completes on the bus is first captured in a register. It is offered to the local side one clock later with an acknowledge. It is handed over on a transfer strobe once the local side has shown it is ready. A 10-bit status vector tracks each stage of the transaction: request, grant, address phase, data mode, a completed phase and a 64-bit target.

A read of a single data phase is chosen by raising the last signal before the address phase ends. Memory read, memory read multiple and memory read line commands all pass through unchanged. If no target claims the cycle within a parameterised number of clocks, the block performs a master abort and pulses a separate flag.

Top module: `pmr64_read_master`

## Requirements
- R1: A request (`lreq`) seen in idle drives `req_n` low from the next cycle, and status bit 0 is set while waiting. `req_n` stays low through the address phase and goes high in the first cycle after it.
- R2: The sequencer leaves the request state only on a clock where `gnt_n` is low and both `bus_frame_n` and `bus_irdy_n` are high. It then raises `adr_ack` for exactly one cycle with status bit 1, and `laddr`/`lcmd` are sampled in that cycle.
- R3: In the cycle after `adr_ack`, `frame_n`, `req64_n` and `ad_oe` are asserted. `ad_out[31:0]` carries the sampled address, with the upper lanes at zero. `cbe_out[3:0]` carries the command unchanged for any code (6h, Ch and Eh alike), with `cbe_out[7:4]` at zero. Status bit 2 is set.
- R4: The next cycle is a turnaround. `ad_oe` is low, `cbe_oe` is high and `cbe_out[7:0]` carries the eight byte enables sampled during the address phase. `irdy_n` is low whatever `lrdy` is.
- R5: After the first data phase has completed, `irdy_n` is low only in cycles that follow a cycle with `lrdy` high. A local wait therefore drops `irdy_n` and `ldxfr` in the next cycle, and the pending word stays on `ldata`.
- R6: A data phase completes on a clock where `irdy_n`, `trdy_n` and `devsel_n` are all low. The `ad_in` word is captured, `lack` rises in the next cycle with that word on `ldata`, and status bit 8 is set in that cycle.
- R7: `ldxfr` and `lo_ack` are high exactly when `lack` is high and `lrdy` was high in the previous cycle. `hi_ack` follows `ldxfr` only if the target asserted `ack64_n`, which also sets status bit 9 during data mode.
- R8: If `llast` is high on a clock where a data phase completes, `frame_n` and `req64_n` rise in the next cycle. Exactly one more data phase then runs with `irdy_n` low, and `irdy_n` goes high after it.
- R9: If `llast` is raised anywhere from the request to the address phase, `frame_n` is already high in the turnaround cycle. Exactly one data phase occurs.
- R10: A target wait (`trdy_n` high) removes `lack` and `ldxfr` in the next cycle once the pending word has been delivered.
- R11: If `devsel_n` stays high for DEVSEL_WAIT (default 5) cycles starting at the turnaround, the sequencer returns to idle. `abort_flag` pulses for one cycle, with all bus controls released and status zero.
- R12: Status bit 3 is set from the turnaround until the last word has been delivered, bits 7:4 are always zero, and after reset all active-low bus controls are high, both enables are low and status is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lreq | input | 1 | Local 64-bit read request |
| llast | input | 1 | Local last-word indication |
| lrdy | input | 1 | Local side ready to accept data |
| laddr | input | 32 | Local address, sampled during `adr_ack` |
| lcmd | input | 4 | Local bus command, sampled during `adr_ack` |
| lbe | input | 8 | Byte enables, sampled during address phase |
| adr_ack | output | 1 | Address/command acknowledge to local side |
| lack | output | 1 | A captured word is waiting on `ldata` |
| ldxfr | output | 1 | Local transfer strobe |
| lo_ack | output | 1 | Low-half data acknowledge |
| hi_ack | output | 1 | High-half data acknowledge |
| ldata | output | 64 | Word delivered to local side |
| status | output | 10 | Transaction stage vector |
| abort_flag | output | 1 | One-cycle master-abort pulse |
| req_n | output | 1 | Bus request to arbiter |
| gnt_n | input | 1 | Bus grant from arbiter |
| bus_frame_n | input | 1 | Observed bus frame |
| bus_irdy_n | input | 1 | Observed bus initiator ready |
| frame_n | output | 1 | Driven frame |
| req64_n | output | 1 | Driven 64-bit request |
| irdy_n | output | 1 | Driven initiator ready |
| ctl_oe | output | 1 | Enable for frame/req64/irdy drivers |
| ad_out | output | 64 | Address/data lanes out |
| ad_oe | output | 1 | Address/data lane enable |
| ad_in | input | 64 | Address/data lanes in |
| cbe_out | output | 8 | Command/byte-enable lanes |
| cbe_oe | output | 1 | Command/byte-enable enable |
| devsel_n | input | 1 | Target device select |
| trdy_n | input | 1 | Target ready |
| ack64_n | input | 1 | Target 64-bit acknowledge |

## Verification
The assertions check the local-side rules on every cycle:
- the address acknowledge sits inside the bus request;
- the address phase follows the acknowledge;
- the turnaround releases the lanes and raises initiator-ready;
- initiator-ready after the first phase is gated by the previous cycle's local ready;
- each completion is followed by an acknowledge;
- the strobes obey their ready/acknowledge rule;
- frame never rises without initiator-ready except on abort;
- the stage bits stay one-hot.

Only the bench scenarios can show the end-to-end orderings:
- the exact data word delivered per cycle;
- that last ends the burst after exactly one more phase;
- single-phase selection before the address phase;
- grant being held off by a busy bus;
- the abort firing on precisely the fifth unclaimed cycle.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_AACK, ST_ADDR, ST_DATA, ST_DRAIN
  } pmr_st_t;

  localparam int STAT_W = 10;

  // Stage vector: one bit per stage plus phase-done and wide-target flags.
  function automatic logic [STAT_W-1:0] status_word(pmr_st_t s, logic done_q, logic wide);
    logic [STAT_W-1:0] w;
    w    = '0;
    w[0] = (s == ST_REQ);
    w[1] = (s == ST_AACK);
    w[2] = (s == ST_ADDR);
    w[3] = (s == ST_DATA) || (s == ST_DRAIN);
    w[8] = done_q;
    w[9] = wide && w[3];
    return w;
  endfunction

  // Initiator-ready: unconditional for the first phase, else gated by local ready.
  function automatic logic irdy_wanted(logic in_data, logic first_pend, logic rdy_q);
    return in_data && (first_pend || rdy_q);
  endfunction

endpackage

// File: rtl/pmr_bus_fsm.sv
module pmr_bus_fsm
  import pmr_pkg::*;
#(
  parameter int DEVSEL_WAIT = 5,
  localparam int CW = $clog2(DEVSEL_WAIT + 1)
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    lreq,
  input  logic    llast,
  input  logic    gnt_n,
  input  logic    bus_frame_n,
  input  logic    bus_irdy_n,
  input  logic    devsel_n,
  input  logic    trdy_n,
  input  logic    ack64_n,
  input  logic    rdy_q,
  input  logic    word_pending,
  input  logic    dxfr,
  output pmr_st_t st,
  output logic    first_pend,
  output logic    fin,
  output logic    irdy_on,
  output logic    xfer,
  output logic    xfer_q,
  output logic    wide,
  output logic    abort_q
);

  pmr_st_t       st_nxt;
  logic          last_q;
  logic          claimed;
  logic [CW-1:0] dcnt;
  logic          abort_now;
  logic          last_now;
  logic          bus_idle;

  assign bus_idle  = bus_frame_n && bus_irdy_n;
  assign last_now  = last_q || llast;
  assign irdy_on   = irdy_wanted(st == ST_DATA, first_pend, rdy_q);
  assign xfer      = irdy_on && !trdy_n && !devsel_n;
  assign abort_now = (st == ST_DATA) && !claimed && devsel_n && (dcnt == CW'(DEVSEL_WAIT - 1));

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_IDLE:  if (lreq) st_nxt = ST_REQ;
      ST_REQ:   if (!gnt_n && bus_idle) st_nxt = ST_AACK;
      ST_AACK:  st_nxt = ST_ADDR;
      ST_ADDR:  st_nxt = ST_DATA;
      ST_DATA: begin
        if (abort_now)       st_nxt = ST_IDLE;
        else if (xfer && fin) st_nxt = ST_DRAIN;
      end
      ST_DRAIN: if (!word_pending || dxfr) st_nxt = ST_IDLE;
      default:  st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      last_q     <= 1'b0;
      fin        <= 1'b0;
      first_pend <= 1'b0;
      claimed    <= 1'b0;
      dcnt       <= '0;
      wide       <= 1'b0;
      xfer_q     <= 1'b0;
      abort_q    <= 1'b0;
    end else begin
      st      <= st_nxt;
      xfer_q  <= xfer;
      abort_q <= abort_now;
      if (st == ST_IDLE) last_q <= lreq && llast;
      else if (llast)    last_q <= 1'b1;
      case (st)
        ST_ADDR: begin
          fin        <= last_now;
          first_pend <= 1'b1;
          claimed    <= 1'b0;
          dcnt       <= '0;
          wide       <= 1'b0;
        end
        ST_DATA: begin
          if (xfer && last_now) fin <= 1'b1;
          if (xfer) first_pend <= 1'b0;
          if (!devsel_n) claimed <= 1'b1;
          else if (!claimed) dcnt <= dcnt + 1'b1;
          if (!devsel_n && !ack64_n) wide <= 1'b1;
        end
        ST_IDLE: fin <= 1'b0;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pmr_local_port.sv
module pmr_local_port #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lrdy,
  input  logic          xfer,
  input  logic [DW-1:0] ad_in,
  output logic          rdy_q,
  output logic          ack_q,
  output logic          dxfr,
  output logic [DW-1:0] data_q
);

  assign dxfr = ack_q && rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      ack_q  <= 1'b0;
      data_q <= '0;
    end else begin
      rdy_q <= lrdy;
      if (xfer) begin
        data_q <= ad_in;
        ack_q  <= 1'b1;
      end else if (dxfr) begin
        ack_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pmr64_read_master.sv
module pmr64_read_master
  import pmr_pkg::*;
#(
  parameter int DW = 64,
  parameter int AW = 32,
  parameter int DEVSEL_WAIT = 5,
  localparam int BEW = DW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lreq,
  input  logic              llast,
  input  logic              lrdy,
  input  logic [AW-1:0]     laddr,
  input  logic [3:0]        lcmd,
  input  logic [BEW-1:0]    lbe,
  output logic              adr_ack,
  output logic              lack,
  output logic              ldxfr,
  output logic              lo_ack,
  output logic              hi_ack,
  output logic [DW-1:0]     ldata,
  output logic [STAT_W-1:0] status,
  output logic              abort_flag,
  output logic              req_n,
  input  logic              gnt_n,
  input  logic              bus_frame_n,
  input  logic              bus_irdy_n,
  output logic              frame_n,
  output logic              req64_n,
  output logic              irdy_n,
  output logic              ctl_oe,
  output logic [DW-1:0]     ad_out,
  output logic              ad_oe,
  input  logic [DW-1:0]     ad_in,
  output logic [BEW-1:0]    cbe_out,
  output logic              cbe_oe,
  input  logic              devsel_n,
  input  logic              trdy_n,
  input  logic              ack64_n
);

  pmr_st_t        st;
  logic           first_pend, fin, irdy_on, xfer, xfer_q, wide, abort_q;
  logic           rdy_q, ack_q, dxfr;
  logic [AW-1:0]  addr_q;
  logic [3:0]     cmd_q;
  logic [BEW-1:0] be_q;

  pmr_bus_fsm #(.DEVSEL_WAIT(DEVSEL_WAIT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .lreq(lreq), .llast(llast), .gnt_n(gnt_n),
    .bus_frame_n(bus_frame_n), .bus_irdy_n(bus_irdy_n), .devsel_n(devsel_n),
    .trdy_n(trdy_n), .ack64_n(ack64_n), .rdy_q(rdy_q), .word_pending(ack_q),
    .dxfr(dxfr), .st(st), .first_pend(first_pend), .fin(fin), .irdy_on(irdy_on),
    .xfer(xfer), .xfer_q(xfer_q), .wide(wide), .abort_q(abort_q)
  );

  pmr_local_port #(.DW(DW)) u_lport (
    .clk(clk), .rst_n(rst_n), .lrdy(lrdy), .xfer(xfer), .ad_in(ad_in),
    .rdy_q(rdy_q), .ack_q(ack_q), .dxfr(dxfr), .data_q(ldata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cmd_q  <= '0;
      be_q   <= '0;
    end else begin
      if (st == ST_AACK) begin
        addr_q <= laddr;
        cmd_q  <= lcmd;
      end
      if (st == ST_ADDR) be_q <= lbe;
    end
  end

  assign req_n      = !(st == ST_REQ || st == ST_AACK || st == ST_ADDR);
  assign adr_ack    = (st == ST_AACK);
  assign frame_n    = !(st == ST_ADDR || (st == ST_DATA && !fin));
  assign req64_n    = frame_n;
  assign irdy_n     = !irdy_on;
  assign ctl_oe     = (st == ST_AACK) || (st == ST_ADDR) || (st == ST_DATA) || (st == ST_DRAIN);
  assign ad_oe      = (st == ST_ADDR);
  assign ad_out     = ad_oe ? {{(DW-AW){1'b0}}, addr_q} : '0;
  assign cbe_oe     = (st == ST_ADDR) || (st == ST_DATA);
  assign cbe_out    = (st == ST_ADDR) ? {{(BEW-4){1'b0}}, cmd_q} : be_q;
  assign lack       = ack_q;
  assign ldxfr      = dxfr;
  assign lo_ack     = dxfr;
  assign hi_ack     = dxfr && wide;
  assign status     = status_word(st, xfer_q, wide);
  assign abort_flag = abort_q;

endmodule

// File: rtl/pmr64_read_master_chk.sv
module pmr64_read_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lrdy,
  input logic       adr_ack,
  input logic       req_n,
  input logic       frame_n,
  input logic       req64_n,
  input logic       irdy_n,
  input logic       ad_oe,
  input logic       cbe_oe,
  input logic       lack,
  input logic       ldxfr,
  input logic       lo_ack,
  input logic       hi_ack,
  input logic [9:0] status,
  input logic       abort_flag,
  input logic       first_pend,
  input logic       xfer
);

  a_r2_ack_inside_req: assert property (@(posedge clk) disable iff (!rst_n)
    adr_ack |-> !req_n);

  a_r3_addr_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    adr_ack |=> (!frame_n && !req64_n && ad_oe && !req_n));

  a_r4_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |=> (!ad_oe && cbe_oe && !irdy_n && req_n));

  a_r5_irdy_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && !first_pend) |-> $past(lrdy));

  a_r6_capture_then_ack: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (lack && status[8]));

  a_r7_strobe_rule: assert property (@(posedge clk) disable iff (!rst_n)
    ldxfr |-> (lack && $past(lrdy)));

  a_r7_halves: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_ack == ldxfr) && (!hi_ack || lo_ack));

  a_r8_frame_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(frame_n) && !abort_flag) |-> !irdy_n);

  a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort_flag |-> (req_n && irdy_n && frame_n && status == 10'd0));

  a_r12_stage_bits: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status[3:0]) && (status[7:4] == 4'd0));

endmodule

bind pmr64_read_master pmr64_read_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lrdy(lrdy), .adr_ack(adr_ack), .req_n(req_n),
  .frame_n(frame_n), .req64_n(req64_n), .irdy_n(irdy_n), .ad_oe(ad_oe),
  .cbe_oe(cbe_oe), .lack(lack), .ldxfr(ldxfr), .lo_ack(lo_ack), .hi_ack(hi_ack),
  .status(status), .abort_flag(abort_flag), .first_pend(first_pend), .xfer(xfer)
);

// File: tb/pmr64_read_master_test.sv
`timescale 1ns/1ps
module pmr64_read_master_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lreq, llast, lrdy;
  logic [31:0] laddr;
  logic [3:0]  lcmd;
  logic [7:0]  lbe;
  logic        adr_ack, lack, ldxfr, lo_ack, hi_ack, abort_flag;
  logic [63:0] ldata, ad_out, ad_in;
  logic [9:0]  status;
  logic        req_n, gnt_n, bus_frame_n, bus_irdy_n, frame_n, req64_n, irdy_n, ctl_oe;
  logic        ad_oe, cbe_oe, devsel_n, trdy_n, ack64_n;
  logic [7:0]  cbe_out;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pmr64_read_master uut (
    .clk(clk), .rst_n(rst_n), .lreq(lreq), .llast(llast), .lrdy(lrdy),
    .laddr(laddr), .lcmd(lcmd), .lbe(lbe), .adr_ack(adr_ack), .lack(lack),
    .ldxfr(ldxfr), .lo_ack(lo_ack), .hi_ack(hi_ack), .ldata(ldata),
    .status(status), .abort_flag(abort_flag), .req_n(req_n), .gnt_n(gnt_n),
    .bus_frame_n(bus_frame_n), .bus_irdy_n(bus_irdy_n), .frame_n(frame_n),
    .req64_n(req64_n), .irdy_n(irdy_n), .ctl_oe(ctl_oe), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in), .cbe_out(cbe_out), .cbe_oe(cbe_oe),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .ack64_n(ack64_n)
  );

  typedef struct packed {
    logic       lreq, llast, lrdy, gnt_n, dsel_n, trdy_n, ack64_n;
    logic       e_req_n, e_aack, e_frame_n, e_irdy_n, e_dxfr;
    logic [9:0] e_stat;
  } row_t;

  // Zero-wait burst of three words, one row per clock.
  localparam row_t TBL [0:9] = '{
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b1,1'b1,1'b0, 10'h000},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1, 1'b0,1'b0,1'b1,1'b1,1'b0, 10'h001},
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 1'b0,1'b1,1'b1,1'b1,1'b0, 10'h002},
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b1,1'b0, 10'h004},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0, 10'h008},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0, 10'h208},
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b1, 10'h308},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0,1'b1, 10'h308},
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b1,1'b1,1'b1, 10'h308},
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b1,1'b1,1'b0, 10'h000}
  };

  localparam logic [63:0] BASE = 64'hD0D0_0000_0000_0000;
  localparam logic [31:0] ADR  = 32'h1234_5678;
  localparam logic [7:0]  BEV  = 8'hA5;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  task automatic bus_release();
    devsel_n = 1'b1; trdy_n = 1'b1; ack64_n = 1'b1; lrdy = 1'b0; llast = 1'b0;
  endtask

  // From idle to the turnaround cycle; returns at the negedge of the turnaround.
  task automatic to_data(input logic early_last, input logic [3:0] cmd);
    lreq = 1'b1; llast = early_last;
    @(negedge clk);
    lreq = 1'b0; llast = 1'b0; gnt_n = 1'b0;
    @(negedge clk);
    gnt_n = 1'b1; laddr = ADR; lcmd = cmd;
    @(negedge clk);
    chk("R3 command lanes", {60'd0, cbe_out[3:0]}, {60'd0, cmd});
    lbe = BEV; lrdy = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; lreq = 1'b0; llast = 1'b0; lrdy = 1'b0; laddr = '0; lcmd = '0; lbe = '0;
    gnt_n = 1'b1; bus_frame_n = 1'b1; bus_irdy_n = 1'b1; ad_in = '0;
    devsel_n = 1'b1; trdy_n = 1'b1; ack64_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 reset status", {54'd0, status}, 64'd0);
    chk("R12 reset controls", {58'd0, req_n, frame_n, irdy_n, req64_n, ad_oe, cbe_oe},
        {58'd0, 6'b111100});
    chk("R12 reset ctl_oe", {63'd0, ctl_oe}, 64'd0);
    rst_n = 1'b1;

    // Table-driven zero-wait burst.
    laddr = ADR; lcmd = 4'h6; lbe = BEV;
    for (int i = 0; i < 10; i++) begin
      chk("R1 req_n", {63'd0, req_n}, {63'd0, TBL[i].e_req_n});
      chk("R2 adr_ack", {63'd0, adr_ack}, {63'd0, TBL[i].e_aack});
      chk("R8 frame_n", {63'd0, frame_n}, {63'd0, TBL[i].e_frame_n});
      chk("R5 irdy_n", {63'd0, irdy_n}, {63'd0, TBL[i].e_irdy_n});
      chk("R7 ldxfr", {63'd0, ldxfr}, {63'd0, TBL[i].e_dxfr});
      chk("R12 status", {54'd0, status}, {54'd0, TBL[i].e_stat});
      if (TBL[i].e_dxfr) begin
        chk("R6 word", ldata, BASE + 64'(i - 1));
        chk("R7 halves", {62'd0, lo_ack, hi_ack}, {62'd0, 2'b11});
      end
      if (i == 3) begin
        chk("R3 address lanes", ad_out, {32'd0, ADR});
        chk("R3 cbe", {55'd0, ad_oe, cbe_out}, {55'd0, 1'b1, 8'h06});
      end
      if (i == 4) chk("R4 turnaround", {54'd0, ad_oe, cbe_oe, cbe_out}, {54'd0, 2'b01, BEV});
      lreq = TBL[i].lreq; llast = TBL[i].llast; lrdy = TBL[i].lrdy; gnt_n = TBL[i].gnt_n;
      devsel_n = TBL[i].dsel_n; trdy_n = TBL[i].trdy_n; ack64_n = TBL[i].ack64_n;
      ad_in = BASE + 64'(i);
      @(negedge clk);
    end
    bus_release();

    // Single data phase, last raised with the request, command Ch.
    to_data(1'b1, 4'hC);
    chk("R9 frame high at turnaround", {62'd0, frame_n, req64_n}, {62'd0, 2'b11});
    chk("R9 irdy at turnaround", {63'd0, irdy_n}, 64'd0);
    devsel_n = 1'b0; trdy_n = 1'b0; ack64_n = 1'b0; ad_in = 64'h5151_0000_0000_0001;
    @(negedge clk);
    chk("R9 one phase only", {62'd0, irdy_n, ldxfr}, {62'd0, 2'b11});
    chk("R9 word", ldata, 64'h5151_0000_0000_0001);
    chk("R12 data mode in drain", {63'd0, status[3]}, 64'd1);
    bus_release();
    @(negedge clk);
    chk("R12 idle after single", {54'd0, status}, 64'd0);

    // Local wait inside a burst, command Eh.
    to_data(1'b0, 4'hE);
    devsel_n = 1'b0; ack64_n = 1'b0; trdy_n = 1'b0; ad_in = 64'h10;
    @(negedge clk);
    chk("R6 first word", ldata, 64'h10);
    lrdy = 1'b0; ad_in = 64'h11;
    @(negedge clk);
    chk("R5 local wait irdy", {63'd0, irdy_n}, 64'd1);
    chk("R5 local wait strobe", {62'd0, lack, ldxfr}, {62'd0, 2'b10});
    chk("R5 word held", ldata, 64'h11);
    lrdy = 1'b1; ad_in = 64'h99;
    @(negedge clk);
    chk("R5 resume", {62'd0, irdy_n, ldxfr}, {62'd0, 2'b01});
    chk("R5 resumed word", ldata, 64'h11);
    llast = 1'b1; ad_in = 64'h12;
    @(negedge clk);
    chk("R8 frame after last", {61'd0, frame_n, req64_n, irdy_n}, {61'd0, 3'b110});
    chk("R8 word", ldata, 64'h12);
    llast = 1'b0; ad_in = 64'h13;
    @(negedge clk);
    chk("R8 final phase then release", {62'd0, irdy_n, ldxfr}, {62'd0, 2'b11});
    chk("R8 final word", ldata, 64'h13);
    bus_release();
    @(negedge clk);
    chk("R12 idle after local wait", {54'd0, status}, 64'd0);

    // Target wait with a 32-bit target (no ack64).
    to_data(1'b0, 4'h6);
    devsel_n = 1'b0; ack64_n = 1'b1; trdy_n = 1'b0; ad_in = 64'h20;
    @(negedge clk);
    chk("R7 low half only", {61'd0, ldxfr, lo_ack, hi_ack}, {61'd0, 3'b110});
    chk("R7 no wide status", {63'd0, status[9]}, 64'd0);
    trdy_n = 1'b1;
    @(negedge clk);
    chk("R10 target wait", {61'd0, lack, ldxfr, status[8]}, 64'd0);
    trdy_n = 1'b0; llast = 1'b1; ad_in = 64'h21;
    @(negedge clk);
    chk("R10 resumed word", ldata, 64'h21);
    chk("R8 frame high", {63'd0, frame_n}, 64'd1);
    llast = 1'b0; ad_in = 64'h22;
    @(negedge clk);
    chk("R8 last word", {62'd0, ldxfr, irdy_n}, {62'd0, 2'b11});
    bus_release();
    @(negedge clk);

    // Grant held off by a busy bus, then master abort.
    lreq = 1'b1;
    @(negedge clk);
    lreq = 1'b0; gnt_n = 1'b0; bus_frame_n = 1'b0;
    @(negedge clk);
    chk("R2 busy frame blocks", {62'd0, adr_ack, status[0]}, {62'd0, 2'b01});
    bus_frame_n = 1'b1; bus_irdy_n = 1'b0;
    @(negedge clk);
    chk("R2 busy irdy blocks", {63'd0, adr_ack}, 64'd0);
    bus_irdy_n = 1'b1;
    @(negedge clk);
    chk("R2 grant on idle bus", {63'd0, adr_ack}, 64'd1);
    gnt_n = 1'b1; lrdy = 1'b1;
    @(negedge clk);
    @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      chk("R11 no early abort", {62'd0, abort_flag, irdy_n}, 64'd0);
      @(negedge clk);
    end
    chk("R11 abort pulse", {62'd0, abort_flag, irdy_n}, {62'd0, 2'b11});
    chk("R11 status idle", {54'd0, status}, 64'd0);
    @(negedge clk);
    chk("R11 pulse ends", {63'd0, abort_flag}, 64'd0);

    finish_up();
  end

endmodule